// File: doc/BRIEF.md
# Multiplexed-Bus Port Decoder

This block sits beside an 8-bit microcontroller whose external bus carries two things on the same eight pins. Early in each bus cycle those pins hold the low address byte, and later in the cycle they hold data. The block keeps a copy of the low address byte. It treats the top address bit as a decode enable and turns three further high-address bits into one of eight port selects. Firmware reaches the ports by accessing memory addresses that would otherwise be unused, so no separate I/O space is needed.

A write to a select that maps to an output port loads the bus data into that port's register. A read from a select that maps to an input port raises that source's output enable and drives its value onto the bus. All bus pins are sampled on the block clock, which must be fast enough to see every strobe level for at least one cycle. The processor sets the timing of every bus cycle, so the bus is plain strobe-and-level signalling with no back-pressure. The block never stalls the processor, and it has no valid/ready handshake.

Top module: `mmio_bus_decoder`

## Requirements
- R1: `addr_lo` takes the value of `bus_in` at the clock edge where `ale` is seen low after having been high one edge earlier. It keeps that value until the next such edge.
- R2: An edge where `wr_n` is seen high after being low one edge earlier is a write edge. At a write edge, if `addr_hi[7]` is 1 and the select `addr_hi[6:4]` is k with 0 <= k <= 2, byte k of `out_ports` (bits 8k+7:8k) is loaded with `bus_in`.
- R3: A write edge while `addr_hi[7]` is 0 changes no output register.
- R4: A write changes only the register named by its select. The other output registers keep their values.
- R5: A write edge with select 3 to 7 changes no output register.
- R6: While `rd_n` is 0, `addr_hi[7]` is 1 and the select s is 4 to 7, the following hold together: `bus_oe` is 1, `in_oe` has only bit s-4 set, and `bus_out` equals byte s-4 of `in_ports`. All three are combinational and follow the inputs in the same cycle.
- R7: A read with `addr_hi[7]` 0, a read with a select of 0 to 3, or no read at all gives `bus_oe` 0, `in_oe` 0 and `bus_out` 0x00.
- R8: A synchronous reset (`rst` high at a clock edge) clears all output registers and `addr_lo` to 0x00.
- R9: Holding `wr_n` low for several cycles, or changing `bus_in` while `wr_n` stays high, loads nothing. Only the rising transition of `wr_n` loads data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples the bus strobes |
| rst | input | 1 | Synchronous active-high reset |
| ale | input | 1 | Address-latch strobe; the low byte is captured on its falling edge |
| wr_n | input | 1 | Active-low write strobe; data is loaded on its rising edge |
| rd_n | input | 1 | Active-low read strobe |
| addr_hi | input | 8 | High address byte; bit 7 enables decode, bits 6:4 are the select |
| bus_in | input | 8 | Value on the shared address/data pins |
| bus_out | output | 8 | Value to drive onto the shared pins during a port read |
| bus_oe | output | 1 | Pin driver enable for `bus_out`; the pins are tri-stated when it is low |
| addr_lo | output | 8 | Held low address byte |
| in_ports | input | 32 | Four input sources; source j is in bits 8j+7:8j |
| in_oe | output | 4 | Per-source output enable, one-hot or zero |
| out_ports | output | 24 | Three output registers; register k is in bits 8k+7:8k |

## Verification
The hardest case to reach is a bus cycle whose strobe edges and data changes fall in different clock cycles. Examples are `wr_n` held low across several edges while `bus_in` moves, `bus_in` changing while `wr_n` stays high, and the high address changing between a write and its neighbours. Directed tasks build complete bus cycles with drawn-out strobe phases. A randomised phase then drives every pin independently on each cycle, which produces edge patterns that no well-formed processor cycle would. A behavioural model checks the outputs against the strobe history on every clock.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HI_W   = 8;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned N_SEL  = 1 << SEL_W;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [SEL_W-1:0]  sel_t;

  function automatic sel_t hi_to_sel(input logic [HI_W-1:0] hi);
    return hi[HI_W-2 -: SEL_W];
  endfunction
endpackage

// File: rtl/mmio_edge_det.sv
module mmio_edge_det #(
  parameter bit DETECT_FALL = 1'b1,
  parameter bit IDLE_LEVEL  = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  output logic edge_seen
);
  logic level_q;

  always_ff @(posedge clk) begin
    if (rst) level_q <= IDLE_LEVEL;
    else     level_q <= level_in;
  end

  generate
    if (DETECT_FALL) begin : g_fall
      assign edge_seen = level_q & ~level_in;
    end else begin : g_rise
      assign edge_seen = ~level_q & level_in;
    end
  endgenerate
endmodule

// File: rtl/mmio_addr_latch.sv
module mmio_addr_latch
  import mmio_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  capture,
  input  byte_t bus_in,
  output byte_t held
);
  always_ff @(posedge clk) begin
    if (rst)          held <= '0;
    else if (capture) held <= bus_in;
  end
endmodule

// File: rtl/mmio_sel_decode.sv
module mmio_sel_decode
  import mmio_pkg::*;
#(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned IN_BASE = 4,
  parameter int unsigned NUM_IN  = 4
) (
  input  logic [HI_W-1:0]    addr_hi,
  output logic [NUM_OUT-1:0] wr_hit,
  output logic [NUM_IN-1:0]  rd_hit,
  output logic               rd_any
);
  logic  enable;
  sel_t  sel;
  logic [N_SEL-1:0] onehot;

  assign enable = addr_hi[HI_W-1];
  assign sel    = hi_to_sel(addr_hi);

  always_comb begin
    onehot = '0;
    if (enable) onehot[sel] = 1'b1;
  end

  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_wr
      assign wr_hit[k] = onehot[k];
    end
    for (genvar j = 0; j < NUM_IN; j++) begin : g_rd
      assign rd_hit[j] = onehot[IN_BASE + j];
    end
  endgenerate

  assign rd_any = enable && (int'(sel) >= IN_BASE) && (int'(sel) < IN_BASE + NUM_IN);
endmodule

// File: rtl/mmio_out_bank.sv
module mmio_out_bank
  import mmio_pkg::*;
#(
  parameter int unsigned NUM_OUT = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_edge,
  input  logic [NUM_OUT-1:0]        wr_hit,
  input  byte_t                     bus_in,
  output logic [NUM_OUT*BYTE_W-1:0] regs_flat
);
  generate
    for (genvar k = 0; k < NUM_OUT; k++) begin : g_reg
      byte_t r_q;
      always_ff @(posedge clk) begin
        if (rst)                    r_q <= '0;
        else if (wr_edge && wr_hit[k]) r_q <= bus_in;
      end
      assign regs_flat[k*BYTE_W +: BYTE_W] = r_q;
    end
  endgenerate
endmodule

// File: rtl/mmio_rd_mux.sv
module mmio_rd_mux
  import mmio_pkg::*;
#(
  parameter int unsigned NUM_IN = 4
) (
  input  logic                     rd_n,
  input  logic [NUM_IN-1:0]        rd_hit,
  input  logic                     rd_any,
  input  logic [NUM_IN*BYTE_W-1:0] in_flat,
  output logic [NUM_IN-1:0]        in_oe,
  output logic                     bus_oe,
  output byte_t                    bus_out
);
  assign in_oe  = rd_n ? '0 : rd_hit;
  assign bus_oe = ~rd_n & rd_any;

  always_comb begin
    bus_out = '0;
    for (int j = 0; j < NUM_IN; j++) begin
      if (in_oe[j]) bus_out = bus_out | in_flat[j*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
  import mmio_pkg::*;
#(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned IN_BASE = 4,
  parameter int unsigned NUM_IN  = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ale,
  input  logic                      wr_n,
  input  logic                      rd_n,
  input  logic [HI_W-1:0]           addr_hi,
  input  logic [BYTE_W-1:0]         bus_in,
  output logic [BYTE_W-1:0]         bus_out,
  output logic                      bus_oe,
  output logic [BYTE_W-1:0]         addr_lo,
  input  logic [NUM_IN*BYTE_W-1:0]  in_ports,
  output logic [NUM_IN-1:0]         in_oe,
  output logic [NUM_OUT*BYTE_W-1:0] out_ports
);
  logic ale_fall, wr_rise, rd_any;
  logic [NUM_OUT-1:0] wr_hit;
  logic [NUM_IN-1:0]  rd_hit;

  mmio_edge_det #(.DETECT_FALL(1'b1), .IDLE_LEVEL(1'b0)) u_ale_edge (
    .clk(clk), .rst(rst), .level_in(ale), .edge_seen(ale_fall));

  mmio_edge_det #(.DETECT_FALL(1'b0), .IDLE_LEVEL(1'b1)) u_wr_edge (
    .clk(clk), .rst(rst), .level_in(wr_n), .edge_seen(wr_rise));

  mmio_addr_latch u_lo (
    .clk(clk), .rst(rst), .capture(ale_fall), .bus_in(bus_in), .held(addr_lo));

  mmio_sel_decode #(.NUM_OUT(NUM_OUT), .IN_BASE(IN_BASE), .NUM_IN(NUM_IN)) u_dec (
    .addr_hi(addr_hi), .wr_hit(wr_hit), .rd_hit(rd_hit), .rd_any(rd_any));

  mmio_out_bank #(.NUM_OUT(NUM_OUT)) u_bank (
    .clk(clk), .rst(rst), .wr_edge(wr_rise), .wr_hit(wr_hit),
    .bus_in(bus_in), .regs_flat(out_ports));

  mmio_rd_mux #(.NUM_IN(NUM_IN)) u_rd (
    .rd_n(rd_n), .rd_hit(rd_hit), .rd_any(rd_any), .in_flat(in_ports),
    .in_oe(in_oe), .bus_oe(bus_oe), .bus_out(bus_out));
endmodule

// File: rtl/mmio_bus_decoder_chk.sv
module mmio_bus_decoder_chk #(
  parameter int unsigned NUM_OUT = 3,
  parameter int unsigned NUM_IN  = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 ale,
  input logic                 wr_n,
  input logic                 rd_n,
  input logic [7:0]           addr_hi,
  input logic [7:0]           addr_lo,
  input logic                 bus_oe,
  input logic [NUM_IN-1:0]    in_oe,
  input logic [NUM_OUT*8-1:0] out_ports
);
  p_lo_only_on_ale_fall_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(addr_lo)) |-> ($past(ale, 2) && !$past(ale)));

  p_out_only_on_wr_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$stable(out_ports)) |-> (!$past(wr_n, 2) && $past(wr_n)));

  p_no_write_without_a15_r3: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(addr_hi[7])) |-> $stable(out_ports));

  p_in_oe_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0(in_oe) && (bus_oe == (in_oe != '0)));

  p_no_drive_without_read_r7: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> (!rd_n && addr_hi[7]));

  p_reset_clears_r8: assert property (@(posedge clk)
    $past(rst) |-> (out_ports == '0 && addr_lo == '0));
endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk #(.NUM_OUT(NUM_OUT), .NUM_IN(NUM_IN)) u_chk (
  .clk(clk), .rst(rst), .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .addr_hi(addr_hi),
  .addr_lo(addr_lo), .bus_oe(bus_oe), .in_oe(in_oe), .out_ports(out_ports));

// File: tb/mmio_bus_decoder_tb_top.sv
module mmio_bus_decoder_tb_top;
  logic clk = 0;
  logic rst = 1;
  logic ale = 0, wr_n = 1, rd_n = 1;
  logic [7:0]  addr_hi = 0, bus_in = 0;
  logic [31:0] in_ports = 32'hD4C3_B2A1;
  logic [7:0]  bus_out, addr_lo;
  logic        bus_oe;
  logic [3:0]  in_oe;
  logic [23:0] out_ports;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;

  always #5 clk = ~clk;

  mmio_bus_decoder dut_i (
    .clk(clk), .rst(rst), .ale(ale), .wr_n(wr_n), .rd_n(rd_n), .addr_hi(addr_hi),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .addr_lo(addr_lo),
    .in_ports(in_ports), .in_oe(in_oe), .out_ports(out_ports));

  // Behavioural reference model
  logic [7:0] m_out [3];
  logic [7:0] m_lo;
  logic       m_ale_prev, m_wr_prev;

  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < 3; k++) m_out[k] = 8'h00;
      m_lo = 8'h00; m_ale_prev = 0; m_wr_prev = 1;
    end else begin
      if (m_ale_prev && !ale) m_lo = bus_in;
      if (!m_wr_prev && wr_n && addr_hi[7] && addr_hi[6:4] < 3)
        m_out[addr_hi[6:4]] = bus_in;
      m_ale_prev = ale; m_wr_prev = wr_n;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // Per-clock comparison, sampled mid-cycle
  always @(negedge clk) begin
    if (!done) begin
      logic [2:0] s;
      logic       rd_ok;
      logic [7:0] exp_bus;
      logic [3:0] exp_oe;
      s = addr_hi[6:4];
      rd_ok = !rd_n && addr_hi[7] && s >= 4;
      exp_oe = rd_ok ? (4'b0001 << (s - 3'd4)) : 4'b0000;
      exp_bus = rd_ok ? in_ports[(s - 3'd4)*8 +: 8] : 8'h00;
      check("R1 held low address", {24'h0, addr_lo}, {24'h0, m_lo});
      check("R2 R4 output registers", {8'h0, out_ports}, {8'h0, m_out[2], m_out[1], m_out[0]});
      check("R6 R7 bus enable", {31'h0, bus_oe}, {31'h0, rd_ok});
      check("R6 R7 source enables", {28'h0, in_oe}, {28'h0, exp_oe});
      check("R6 R7 bus value", {24'h0, bus_out}, {24'h0, exp_bus});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected<=100000 cycles", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic addr_phase(input bit a15, input logic [2:0] sel, input logic [7:0] lo);
    ale = 1; bus_in = lo; addr_hi = {a15, sel, 4'h5};
    step(2);
    ale = 0;
    step(1);
  endtask

  task automatic wr_cycle(input bit a15, input logic [2:0] sel, input logic [7:0] lo,
                          input logic [7:0] data);
    addr_phase(a15, sel, lo);
    bus_in = data; wr_n = 0;
    step(3);
    wr_n = 1;
    step(1);
    bus_in = ~data;
    step(1);
  endtask

  task automatic rd_cycle(input bit a15, input logic [2:0] sel, input logic [7:0] lo);
    addr_phase(a15, sel, lo);
    bus_in = 8'hZZ ^ 8'h00; bus_in = 8'h3C; rd_n = 0;
    step(2);
    rd_n = 1;
    step(1);
  endtask

  initial begin
    step(3);
    // R8: reset state
    check("R8 reset outputs", {8'h0, out_ports}, 32'h0);
    check("R8 reset low address", {24'h0, addr_lo}, 32'h0);
    rst = 0;
    step(1);

    // R1 R2: writes to each output port
    wr_cycle(1, 3'd0, 8'h11, 8'hA5);
    check("R1 low byte captured", {24'h0, addr_lo}, 32'h11);
    wr_cycle(1, 3'd1, 8'h22, 8'h5A);
    wr_cycle(1, 3'd2, 8'h33, 8'hC3);
    check("R2 R4 three ports written", {8'h0, out_ports}, 32'h00C3_5AA5);

    // R3: A15 clear
    wr_cycle(0, 3'd1, 8'h44, 8'hFF);
    check("R3 write without A15 ignored", {8'h0, out_ports}, 32'h00C3_5AA5);

    // R5: unmapped and input-only selects
    for (int s = 3; s < 8; s++) wr_cycle(1, s[2:0], 8'h55, 8'h99);
    check("R5 writes to selects 3..7 ignored", {8'h0, out_ports}, 32'h00C3_5AA5);

    // R9: data changes while wr_n held high, then long low phase
    addr_hi = 8'h80;
    for (int i = 0; i < 4; i++) begin bus_in = 8'h70 + i[7:0]; step(1); end
    check("R9 no load without wr_n rise", {8'h0, out_ports}, 32'h00C3_5AA5);
    wr_n = 0;
    for (int i = 0; i < 4; i++) begin bus_in = 8'h60 + i[7:0]; step(1); end
    check("R9 no load while wr_n low", {8'h0, out_ports}, 32'h00C3_5AA5);
    bus_in = 8'h6E; wr_n = 1; step(1);
    check("R9 single load on rise", {8'h0, out_ports}, 32'h00C3_5A6E);

    // R6 R7: reads of every select, with and without A15
    for (int s = 0; s < 8; s++) begin
      rd_cycle(1, s[2:0], 8'h80 + s[7:0]);
      rd_cycle(0, s[2:0], 8'h90 + s[7:0]);
    end
    in_ports = 32'h0F1E_2D3C;
    rd_cycle(1, 3'd6, 8'hAB);
    check("R1 low byte after read", {24'h0, addr_lo}, 32'hAB);

    // Randomised pin activity
    for (int i = 0; i < 3000; i++) begin
      ale = $urandom_range(0, 1); wr_n = $urandom_range(0, 1); rd_n = $urandom_range(0, 1);
      addr_hi = 8'($urandom); bus_in = 8'($urandom);
      if (i % 97 == 0) in_ports = $urandom;
      step(1);
    end

    // R8: reset mid-operation
    rst = 1; step(1); rst = 0; ale = 0; wr_n = 1; rd_n = 1;
    check("R8 reset clears outputs", {8'h0, out_ports}, 32'h0);
    check("R8 reset clears low address", {24'h0, addr_lo}, 32'h0);
    step(2);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule